// File: doc/BRIEF.md
# Batch Demodulation Phase Generator

This block turns the end-of-batch phase and frequency estimate of a tracking loop into one demodulation phase per sample of the current batch. Each phase is projected back from the loop's estimate to the moment its sample was taken, then multiplied by a run-time harmonic number. The downstream sine/cosine stage uses the resulting stream, so the ADC samples of a batch can be demodulated against a reference that is not locked to the sampling clock.

Two reference sources are supported. With a timestamped digital reference, the loop estimate is in units of a wrapping timer. The per-sample step and the starting offset then need wide reciprocal divisions, which run on one shared sequential divider. With a fixed external clock, the step and offset follow from the phase and frequency with a subtraction only. A start strobe captures all inputs. The block stays busy while it computes, and afterwards it emits exactly `N_SAMP` phases on back-to-back cycles.

Top module: `demod_phase_gen`

## Requirements
- R1: After reset, `phase_vld`, `busy` and `div_err` are all 0.
- R2: A `start` seen while `busy` is 0 captures `mode_fixed`, `y`, `f`, `k` and `u`, and `busy` is 1 on the next cycle.
- R3: A `start` seen while `busy` is 1 has no effect. The batch in progress produces the phases of the inputs captured when it began.
- R4: Each accepted batch yields exactly `N_SAMP` cycles of `phase_vld` back to back. Sample i (from 0 to `N_SAMP`-1, in increasing order) carries `phase = u*(i*g + v)`, reduced modulo 2^32.
- R5: With `mode_fixed`=1 (fixed external clock), g = f and v = y - `N_SAMP`*f, both modulo 2^32.
- R6: With `mode_fixed`=0 (timestamp reference), g is the low 32 bits of floor(2^64 / (`N_SAMP`*(f + k*2^32))), where f and k are both unsigned.
- R7: With `mode_fixed`=0, v is the low 32 bits of -(y*2^32)/f, where y is signed, f is unsigned, and the quotient is truncated toward zero.
- R8: With `mode_fixed`=0 and f = 0, no division is done and g and v keep their previous values (0 after reset). `div_err` is 1 from the cycle after such a start until the next accepted start, and that next start clears it unless it also has f = 0 in timestamp mode.
- R9: With `mode_fixed`=1, the first valid phase appears after the second rising edge that follows the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a batch (accepted only when not busy) |
| mode_fixed | input | 1 | 1 = fixed external clock, 0 = timestamp reference |
| y | input | PH_W | Loop phase at end of batch, signed |
| f | input | PH_W | Loop frequency per sample period |
| k | input | GAP_W | Whole timer wraps between the last two loop updates |
| u | input | PH_W | Harmonic multiplier, signed |
| phase | output | PH_W | Demodulation phase for the current sample |
| phase_vld | output | 1 | `phase` holds a valid sample |
| busy | output | 1 | Batch in progress |
| div_err | output | 1 | Latest batch had zero frequency in timestamp mode |

## Verification
The properties assume that `start` and its data are stable at the sampling edge. They also assume that reset is asserted for at least one cycle before the first batch. The divider property assumes that the divisor is never zero when a division starts. The top level guarantees this only by routing zero-frequency batches around the divider, and the stimulus exercises that path on purpose with f = 0 and a non-zero k. The bench drives and samples only on falling edges. It waits for `busy` to fall before it starts a new batch, except in the one scenario that strobes `start` during a division to show that the strobe is ignored.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIVG,
    ST_DIVV,
    ST_GO,
    ST_EMIT
  } dmp_state_t;
endpackage

// File: rtl/dmp_divider.sv
// Unsigned restoring divider, one quotient bit per cycle.
module dmp_divider #(
  parameter int NUM_W = 65,
  parameter int DEN_W = 42
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             done
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] den_r;
  logic [NUM_W-1:0] sh;
  logic [CW-1:0]    cnt;
  logic             run;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             fits;

  always_comb begin
    trial = {rem, sh[NUM_W-1]};
    diff  = trial - {1'b0, den_r};
    fits  = trial >= {1'b0, den_r};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      den_r <= '0;
      sh    <= '0;
      quo   <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem   <= '0;
        den_r <= den;
        sh    <= num;
        quo   <= '0;
        cnt   <= CW'(NUM_W);
        run   <= 1'b1;
      end else if (run) begin
        rem <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        sh  <= sh << 1;
        quo <= {quo[NUM_W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6/R7: the partial remainder stays below the divisor throughout a division
  a_r6_rem_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (rem < den_r));

  // R8: zero-frequency batches never reach the divider
  a_r8_no_zero_div: assert property (@(posedge clk) disable iff (rst)
    go |-> (den != '0));
endmodule

// File: rtl/dmp_emit.sv
// Emits N_SAMP phases u*(i*g+v) on consecutive cycles.
module dmp_emit #(
  parameter int N_SAMP = 4,
  parameter int PH_W   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic [PH_W-1:0] g,
  input  logic [PH_W-1:0] v,
  input  logic [PH_W-1:0] u,
  output logic [PH_W-1:0] phase,
  output logic            vld,
  output logic            last
);
  localparam int LOG_N = $clog2(N_SAMP);
  localparam int IW    = (LOG_N > 0) ? LOG_N : 1;

  logic [PH_W-1:0] acc;
  logic [IW-1:0]   idx;
  logic            act;
  logic [PH_W-1:0] prod;

  always_comb begin
    prod = u * acc;
    last = act && (idx == IW'(N_SAMP - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      idx   <= '0;
      act   <= 1'b0;
      phase <= '0;
      vld   <= 1'b0;
    end else begin
      vld <= act;
      if (go) begin
        acc <= v;
        idx <= '0;
        act <= 1'b1;
      end else if (act) begin
        phase <= prod;
        acc   <= acc + g;
        idx   <= idx + 1'b1;
        if (last) act <= 1'b0;
      end
    end
  end

  // R4: a new burst is never loaded while one is still running
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
    go |-> !act);

  // R4: the burst ends right after its last sample
  a_r4_burst_end: assert property (@(posedge clk) disable iff (rst)
    last |=> (vld && !act));
endmodule

// File: rtl/demod_phase_gen.sv
module demod_phase_gen
  import dmp_pkg::*;
#(
  parameter int N_SAMP = 4,
  parameter int PH_W   = 32,
  parameter int GAP_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode_fixed,
  input  logic [PH_W-1:0]  y,
  input  logic [PH_W-1:0]  f,
  input  logic [GAP_W-1:0] k,
  input  logic [PH_W-1:0]  u,
  output logic [PH_W-1:0]  phase,
  output logic             phase_vld,
  output logic             busy,
  output logic             div_err
);
  localparam int LOG_N = $clog2(N_SAMP);
  localparam int DEN_W = PH_W + GAP_W + LOG_N;
  localparam int NUM_W = 2 * PH_W + 1;

  dmp_state_t       st;
  logic [PH_W-1:0]  y_r, f_r, u_r, g_r, v_r;
  logic [GAP_W-1:0] k_r;
  logic             div_go;
  logic             div_done;
  logic [NUM_W-1:0] div_q;
  logic [NUM_W-1:0] div_num;
  logic [DEN_W-1:0] div_den;
  logic [PH_W-1:0]  y_abs;
  logic [PH_W-1:0]  q_lo;
  logic             em_last;

  always_comb begin
    y_abs = y_r[PH_W-1] ? (~y_r + 1'b1) : y_r;
    q_lo  = div_q[PH_W-1:0];
    if (st == ST_DIVV) begin
      div_num = {1'b0, y_abs, {PH_W{1'b0}}};
      div_den = DEN_W'(f_r);
    end else begin
      div_num = {1'b1, {(NUM_W-1){1'b0}}};
      div_den = DEN_W'({k_r, f_r}) << LOG_N;
    end
    busy = (st != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      y_r     <= '0;
      f_r     <= '0;
      k_r     <= '0;
      u_r     <= '0;
      g_r     <= '0;
      v_r     <= '0;
      div_err <= 1'b0;
      div_go  <= 1'b0;
    end else begin
      div_go <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          y_r <= y;
          f_r <= f;
          k_r <= k;
          u_r <= u;
          if (mode_fixed) begin
            g_r     <= f;
            v_r     <= y - (f << LOG_N);
            div_err <= 1'b0;
            st      <= ST_GO;
          end else if (f == '0) begin
            div_err <= 1'b1;
            st      <= ST_GO;
          end else begin
            div_err <= 1'b0;
            div_go  <= 1'b1;
            st      <= ST_DIVG;
          end
        end
        ST_DIVG: if (div_done) begin
          g_r    <= q_lo;
          div_go <= 1'b1;
          st     <= ST_DIVV;
        end
        ST_DIVV: if (div_done) begin
          v_r <= y_r[PH_W-1] ? q_lo : (~q_lo + 1'b1);
          st  <= ST_GO;
        end
        ST_GO:   st <= ST_EMIT;
        ST_EMIT: if (em_last) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  dmp_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .num(div_num), .den(div_den),
    .quo(div_q), .done(div_done)
  );

  dmp_emit #(.N_SAMP(N_SAMP), .PH_W(PH_W)) u_emit (
    .clk(clk), .rst(rst), .go(st == ST_GO), .g(g_r), .v(v_r), .u(u_r),
    .phase(phase), .vld(phase_vld), .last(em_last)
  );

  // R2: an idle start makes the block busy on the next cycle
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R3: a start during a batch leaves the captured inputs untouched
  a_r3_ignore_busy: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> ($stable(y_r) && $stable(f_r) && $stable(u_r) && $stable(k_r)));

  // R4: samples only come out of a batch that was running
  a_r4_vld_in_batch: assert property (@(posedge clk) disable iff (rst)
    phase_vld |-> $past(busy));

  // R8: a zero-frequency batch keeps the previous step and offset
  a_r8_err_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && div_err) |=> ($stable(g_r) && $stable(v_r)));
endmodule

// File: tb/demod_phase_gen_bench.sv
module demod_phase_gen_bench;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        mode_fixed;
  logic [31:0] y, f, u;
  logic [7:0]  k;
  logic [31:0] phase;
  logic        phase_vld, busy, div_err;

  int total = 0;
  int bad   = 0;
  logic [31:0] mg = '0;
  logic [31:0] mv = '0;

  always #2.5 clk = ~clk;

  demod_phase_gen u_demod_phase_gen (
    .clk(clk), .rst(rst), .start(start), .mode_fixed(mode_fixed),
    .y(y), .f(f), .k(k), .u(u), .phase(phase), .phase_vld(phase_vld),
    .busy(busy), .div_err(div_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ts_g(input logic [31:0] ff, input logic [7:0] kk);
    logic [127:0] d, q;
    d = ({96'd0, ff} + ({120'd0, kk} << 32)) * N;
    q = (128'd1 << 64) / d;
    return q[31:0];
  endfunction

  function automatic logic [31:0] ts_v(input logic [31:0] yy, input logic [31:0] ff);
    logic [31:0]  ya;
    logic [127:0] q;
    ya = yy[31] ? (~yy + 1) : yy;
    q  = ({96'd0, ya} << 32) / {96'd0, ff};
    return yy[31] ? q[31:0] : (~q[31:0] + 1);
  endfunction

  // Run one batch; collect and check N phases against g/v.
  task automatic run(input logic md, input logic [31:0] yy, input logic [31:0] ff,
                     input logic [7:0] kk, input logic [31:0] uu,
                     input logic [31:0] eg, input logic [31:0] ev,
                     input logic exp_err, input bit interfere, input string tag);
    int lat;
    @(negedge clk);
    mode_fixed = md; y = yy; f = ff; k = kk; u = uu; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    chk({"R2 busy after start ", tag}, {31'd0, busy}, 32'd1);
    while (!phase_vld && lat < 1000) begin
      if (interfere && lat == 4) begin
        mode_fixed = 1'b1; y = 32'h1234_5678; f = 32'h0bad_0bad;
        u = 32'd7; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    if (md) chk({"R9 latency ", tag}, lat, 32'd3);
    chk({"R8 err flag ", tag}, {31'd0, div_err}, {31'd0, exp_err});
    for (int i = 0; i < N; i++) begin
      chk({"R4 vld ", tag}, {31'd0, phase_vld}, 32'd1);
      chk({md ? "R5 phase " : "R6 R7 phase ", tag}, phase, uu * (eg * i + ev));
      @(negedge clk);
    end
    chk({"R4 burst length ", tag}, {31'd0, phase_vld}, 32'd0);
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; mode_fixed = 1'b0; y = '0; f = '0; k = '0; u = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 vld", {31'd0, phase_vld}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 err", {31'd0, div_err}, 32'd0);
  endtask

  task automatic t_fixed(input logic [31:0] yy, input logic [31:0] ff, input logic [31:0] uu);
    mg = ff; mv = yy - ff * N;
    run(1'b1, yy, ff, 8'd0, uu, mg, mv, 1'b0, 1'b0, "fixed");
  endtask

  task automatic t_ts(input logic [31:0] yy, input logic [31:0] ff, input logic [7:0] kk,
                      input logic [31:0] uu, input bit interfere);
    mg = ts_g(ff, kk); mv = ts_v(yy, ff);
    run(1'b0, yy, ff, kk, uu, mg, mv, 1'b0, interfere, interfere ? "R3 ignored" : "timestamp");
  endtask

  task automatic t_zero_f(input logic [31:0] yy, input logic [7:0] kk, input logic [31:0] uu);
    run(1'b0, yy, 32'd0, kk, uu, mg, mv, 1'b1, 1'b0, "R8 zero f");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fixed(32'h0000_1000, 32'h0100_0000, 32'd1);
    t_fixed(32'hffff_fff9, 32'hf000_0000, 32'hffff_fffd);
    t_ts(32'hffff_fe0c, 32'd2362232012, 8'd0, 32'd1, 1'b0);
    t_ts(32'd2147483148, 32'd2362232012, 8'd1, 32'd3, 1'b0);
    t_ts(32'h8000_0000, 32'd195225786, 8'd3, 32'hffff_ffff, 1'b0);
    t_zero_f(32'h0000_0777, 8'd2, 32'd5);
    t_ts(32'd400, 32'd100000, 8'd0, 32'd2, 1'b0);
    t_ts(32'hffff_0000, 32'd7777777, 8'd0, 32'd1, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule